// File: doc/BRIEF.md
# Block CRC Residue Checker

This block checks that a block of bytes read from a serial medium arrived intact. It watches the same byte strobe and byte value that the disk receiver hands on. Every byte accepted during a transfer passes through a 16-bit CRC register. The two check bytes that follow a block's payload on the medium go through the same path. Because of how those check bytes are built, a clean block leaves the register at zero, and any nonzero residue is reported as a CRC error.

The block does not need to know how long a block is. The host starts a new block by raising the transfer-enable level, and that rising edge returns the register to zero. Gap bytes of value zero that arrive before the payload leave a zero register unchanged, so they do no harm. The error bit tracks the register at all times. It is meant to be read after the second check byte has gone in.

Top module: `blkcrc_residue_chk`

## Requirements
- R1: While `rst_n` is low and after its release, the register is zero and `crc_err` reads 0.
- R2: On a cycle where `xfer_en` is 1 and was 0 on the previous clock, the register is cleared. If `byte_vld` is also 1 in that cycle, that byte is folded into a zero register.
- R3: A byte is accepted only when `xfer_en` and `byte_vld` are both 1. In any other cycle the register keeps its value, so `crc_err` does not change.
- R4: The CRC uses generator x^16+x^12+x^5+1 in reflected form (0x8408), starts from zero with no final inversion, and takes each byte bit 0 first. The ASCII string "123456789" followed by 0x89 then 0x21 leaves a zero residue; the same string with the check bytes swapped does not.
- R5: A block of one or more payload bytes followed by its check value, low byte first and then high byte, gives `crc_err` = 0.
- R6: Flipping any single bit of the payload or of either check byte gives `crc_err` = 1.
- R7: Bytes of 0x00 accepted while the register is zero keep it at zero. Leading zero bytes therefore do not change the outcome for the block that follows.
- R8: `crc_err` is 1 exactly when the register is nonzero. It reflects a byte accepted at a clock edge from that edge onward. From a zero register, any single nonzero byte makes it 1.
- R9: While `xfer_en` stays high, the register is never cleared. A residue left by a bad block carries into the next block, and that block also reports an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | Transfer enable level; its rising edge starts a new block |
| byte_vld | input | 1 | A byte from the medium is present this cycle |
| byte_dat | input | DATA_W | Byte value from the medium |
| crc_err | output | 1 | 1 when the CRC register is nonzero |

## Verification
The bench sweeps all 256 single-byte values after a clear. A design that missed the clear, or had the wrong shift direction, would leave a stale or zero residue here. It also sends every one-byte payload with its check bytes, plus the published check string. A wrong polynomial, bit order, or check-byte order would then report errors on clean data. Every single-bit corruption of a six-byte frame must be flagged; a design that skipped the check bytes would miss these. The bench also targets the following edge conditions:
- bytes sent while enable is low;
- a byte that lands in the same cycle as the enable edge;
- leading zero bytes;
- a residue carried across blocks without a new edge.

A design that mishandled any of these would show an error flag that was wrongly cleared, or one that stayed set when it should have cleared.

// File: rtl/blkcrc_pkg.sv
`timescale 1ns/1ps
package blkcrc_pkg;

   // Order in which the bits of a byte enter the shift register.
   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } crc_order_e;

   // Generator written in normal (MSB-first) form: x^16+x^12+x^5+1.
   localparam logic [15:0] GEN_CCITT16 = 16'h1021;

endpackage

// File: rtl/blkcrc_rise_det.sv
`timescale 1ns/1ps
module blkcrc_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/blkcrc_byte_step.sv
`timescale 1ns/1ps
module blkcrc_byte_step
   import blkcrc_pkg::*;
#(
   parameter int                 CRC_W  = 16,
   parameter int                 DATA_W = 8,
   parameter logic [CRC_W-1:0]   POLY   = GEN_CCITT16,
   parameter crc_order_e         ORDER  = ORDER_LSB_FIRST
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] dat_in,
   output logic [CRC_W-1:0]  crc_out
);
   function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
      return r;
   endfunction

   localparam logic [CRC_W-1:0] POLY_R = mirror(POLY);

   generate
      if (ORDER == ORDER_LSB_FIRST) begin : g_lsb
         logic [CRC_W-1:0] acc;
         logic             fb;
         always_comb begin
            acc = crc_in;
            fb  = 1'b0;
            for (int b = 0; b < DATA_W; b++) begin
               fb  = acc[0] ^ dat_in[b];
               acc = {1'b0, acc[CRC_W-1:1]} ^ (fb ? POLY_R : '0);
            end
            crc_out = acc;
         end
      end else begin : g_msb
         logic [CRC_W-1:0] acc;
         logic             fb;
         always_comb begin
            acc = crc_in;
            fb  = 1'b0;
            for (int b = 0; b < DATA_W; b++) begin
               fb  = acc[CRC_W-1] ^ dat_in[DATA_W-1-b];
               acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
            end
            crc_out = acc;
         end
      end
   endgenerate
endmodule

// File: rtl/blkcrc_residue_reg.sv
`timescale 1ns/1ps
module blkcrc_residue_reg #(
   parameter int CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic [CRC_W-1:0] nxt,
   output logic [CRC_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (take)  q <= nxt;
      else if (clr)   q <= '0;
   end
endmodule

// File: rtl/blkcrc_residue_chk.sv
`timescale 1ns/1ps
module blkcrc_residue_chk
   import blkcrc_pkg::*;
#(
   parameter int               CRC_W  = 16,
   parameter int               DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY   = GEN_CCITT16,
   parameter crc_order_e       ORDER  = ORDER_LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_en,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_dat,
   output logic              crc_err
);
   generate
      if (CRC_W < 2) begin : g_bad_crc_w
         $error("CRC_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("POLY must have a constant term");
      end
   endgenerate

   logic             blk_start;
   logic             take;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] seed;
   logic [CRC_W-1:0] crc_nxt;

   blkcrc_rise_det u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (xfer_en),
      .rise  (blk_start)
   );

   assign take = xfer_en & byte_vld;
   assign seed = blk_start ? '0 : crc_q;

   blkcrc_byte_step #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY),
      .ORDER  (ORDER)
   ) u_step (
      .crc_in  (seed),
      .dat_in  (byte_dat),
      .crc_out (crc_nxt)
   );

   blkcrc_residue_reg #(
      .CRC_W (CRC_W)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (blk_start),
      .take  (take),
      .nxt   (crc_nxt),
      .q     (crc_q)
   );

   assign crc_err = |crc_q;
endmodule

// File: rtl/blkcrc_residue_sva.sv
`timescale 1ns/1ps
module blkcrc_residue_sva #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_en,
   input logic              byte_vld,
   input logic [DATA_W-1:0] byte_dat,
   input logic              crc_err
);
   // R2: an edge with no byte leaves a zero register
   assert_clear_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xfer_en) && !byte_vld) |=> !crc_err);

   // R3: without an accepted byte or an edge, the flag holds
   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_en || (!byte_vld && !$rose(xfer_en))) |=> $stable(crc_err));

   // R7: zero byte into a zero register stays zero
   assert_zero_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && byte_vld && byte_dat == '0 && (!crc_err || $rose(xfer_en)))
      |=> !crc_err);

   // R8: nonzero byte into a zero register gives a nonzero residue
   assert_nonzero_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && byte_vld && byte_dat != '0 && (!crc_err || $rose(xfer_en)))
      |=> crc_err);
endmodule

bind blkcrc_residue_chk blkcrc_residue_sva #(.DATA_W(DATA_W)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .xfer_en  (xfer_en),
   .byte_vld (byte_vld),
   .byte_dat (byte_dat),
   .crc_err  (crc_err)
);

// File: tb/blkcrc_residue_chk_tb.sv
`timescale 1ns/1ps
module blkcrc_residue_chk_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_en = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_dat = 8'h00;
   logic       crc_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] blk [0:15];
   int         blen;

   always #10 clk = ~clk;

   blkcrc_residue_chk u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer_en  (xfer_en),
      .byte_vld (byte_vld),
      .byte_dat (byte_dat),
      .crc_err  (crc_err)
   );

   function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c ^= 16'h8408;
      end
      return c;
   endfunction

   task automatic check(bit exp, string tag);
      n_chk++;
      if (crc_err !== exp) begin
         n_bad++;
         $display("FAIL %s: crc_err=%0b expected %0b", tag, crc_err, exp);
      end
   endtask

   // All tasks begin and end at a falling edge.
   task automatic feed(logic [7:0] d);
      byte_vld = 1'b1;
      byte_dat = d;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic start_blk();
      xfer_en = 1'b0;
      @(negedge clk);
      xfer_en = 1'b1;
      @(negedge clk);
   endtask

   // Sends blk[0:blen-1] and its check bytes; flip >= 0 inverts that bit.
   task automatic send_blk(int flip);
      logic [15:0] c;
      c = 16'h0000;
      for (int i = 0; i < blen; i++) c = ref_step(c, blk[i]);
      for (int i = 0; i < blen + 2; i++) begin
         logic [7:0] b;
         b = (i < blen) ? blk[i] : ((i == blen) ? c[7:0] : c[15:8]);
         if (flip >= 0 && flip / 8 == i) b[flip % 8] = ~b[flip % 8];
         feed(b);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      logic [15:0] lfsr;
      logic [15:0] s;
      lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      check(1'b0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, "R1 after reset");

      // R4: published check string, right and swapped check-byte order
      start_blk();
      for (int i = 0; i < 9; i++) feed(8'(8'h31 + i));
      feed(8'h89); feed(8'h21);
      check(1'b0, "R4 check string low-first");
      start_blk();
      for (int i = 0; i < 9; i++) feed(8'(8'h31 + i));
      feed(8'h21); feed(8'h89);
      check(1'b1, "R4 check string swapped");

      // R8: every single byte from a clear register
      for (int d = 0; d < 256; d++) begin
         start_blk();
         feed(8'(d));
         check(d != 0, "R8 single byte sweep");
      end

      // R5: every one-byte payload with its check bytes
      for (int d = 0; d < 256; d++) begin
         start_blk();
         blen = 1; blk[0] = 8'(d);
         send_blk(-1);
         check(1'b0, "R5 one-byte block sweep");
      end

      // R5: pseudo-random payloads of lengths 1..12
      for (int k = 0; k < 24; k++) begin
         start_blk();
         blen = (k % 12) + 1;
         for (int i = 0; i < blen; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            blk[i] = lfsr[7:0];
         end
         send_blk(-1);
         check(1'b0, "R5 multi-byte block");
      end

      // R6: every single-bit error over a 4-byte payload plus check bytes
      blen = 4;
      blk[0] = 8'hC3; blk[1] = 8'h00; blk[2] = 8'h5A; blk[3] = 8'hFF;
      for (int b = 0; b < 48; b++) begin
         start_blk();
         send_blk(b);
         check(1'b1, "R6 single-bit corruption");
      end

      // R7: leading zeros, then a block
      start_blk();
      repeat (5) feed(8'h00);
      check(1'b0, "R7 zeros keep zero");
      blen = 3; blk[0] = 8'h01; blk[1] = 8'h2A; blk[2] = 8'h4E;
      send_blk(-1);
      check(1'b0, "R7 block after leading zeros");

      // R3: strobe low with enable high, then bytes with enable low
      start_blk();
      feed(8'h55);
      check(1'b1, "R3 setup nonzero");
      s = ref_step(16'h0000, 8'h55);
      byte_dat = s[7:0];
      repeat (4) @(negedge clk);
      check(1'b1, "R3 strobe low holds");
      xfer_en = 1'b0;
      feed(s[7:0]); feed(s[15:8]);
      check(1'b1, "R3 bytes ignored while disabled");

      // R2: edge with no byte clears
      xfer_en = 1'b1;
      @(negedge clk);
      check(1'b0, "R2 edge clears");

      // R2: byte arriving with the edge is folded from zero
      feed(8'h77);
      check(1'b1, "R2 setup nonzero");
      xfer_en = 1'b0;
      @(negedge clk);
      s = ref_step(16'h0000, 8'h9C);
      xfer_en = 1'b1;
      feed(8'h9C);
      feed(s[7:0]); feed(s[15:8]);
      check(1'b0, "R2 byte on edge cycle");

      // R9: two blocks without a new edge
      start_blk();
      blen = 2; blk[0] = 8'h12; blk[1] = 8'h34;
      send_blk(-1);
      send_blk(-1);
      check(1'b0, "R9 clean blocks back to back");
      send_blk(3);
      check(1'b1, "R9 bad block");
      send_blk(-1);
      check(1'b1, "R9 residue carries over");
      start_blk();
      check(1'b0, "R9 new edge clears");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end
endmodule